// File: doc/BRIEF.md
# Small-Page NAND Boot Reader

This block pulls a boot image out of a small-page NAND flash device over an 8-bit bus and hands it on as a byte stream. After a start pulse it asserts chip enable and sends the device reset command. It waits out the busy period that follows. It then reads page after page, beginning at column 0 of page 0 of block 0.

Every page takes three read commands. The first covers main bytes 0 to 255, the second covers main bytes 256 to 511, and the third covers the 16 spare bytes. Each command is followed by four address bytes and a full busy/ready cycle on the ready line. Main bytes leave on the output stream with the spare flag low. Spare bytes follow on the same stream with the flag high, so a downstream error-correction stage can separate them.

The consumer asserts `stop` when it has enough data. The page in progress finishes, including its spare area, and the block then returns to idle with chip enable released. The flash data bus is split into input, output and output-enable for a bidirectional pad. All strobe widths are set in system clocks.

Top module: `nand_boot_rd`

## Requirements
- R1: While reset is high and after reset, until `start`: `nd_ce_n`, `nd_we_n` and `nd_re_n` are 1; `nd_cle`, `nd_ale`, `nd_dq_oe` and `out_valid` are 0.
- R2: The first bus write after `start` is command 0xFF with `nd_cle` high. No further write strobe starts until `nd_rb` has been seen low and then high.
- R3: For each page p, counting from 0, the writes are three groups in this order: command 0x00, then 0x01, then 0x50. Each command is followed by exactly four address writes with `nd_ale` high carrying 0x00, p[7:0], p[15:8] and p[23:16].
- R4: After the fourth address write, `nd_re_n` does not fall until `nd_rb` has gone low and back high. A falling `nd_re_n` is always seen with `nd_rb` high.
- R5: Every write strobe holds `nd_we_n` low for exactly `cfg_we_len`+1 clocks. CLE, ALE and `nd_dq_o` are stable while it is low.
- R6: Every read strobe holds `nd_re_n` low for exactly `cfg_re_len`+1 clocks. `nd_re_n` stays high for `cfg_setup_len`+1 clocks between strobes.
- R7: Each page yields 512 main bytes with `out_spare`=0, in column order, followed by 16 spare bytes with `out_spare`=1.
- R8: `out_data` is the value on `nd_dq_i` in the last clock of the read strobe. `out_valid` pulses for one clock, in the clock where `nd_re_n` rises.
- R9: A `stop` pulse during page k ends the run after page k's last spare byte. This holds even when the pulse arrives during that byte's recovery. Afterwards `nd_ce_n` returns to 1 with no further strobes or bytes.
- R10: `start` has no effect while a run is active. The byte stream and the command sequence continue unchanged.
- R11: `nd_we_n` and `nd_re_n` are never low together. `nd_dq_oe` is high only during command or address writes, and exactly one of CLE and ALE is high then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a boot read |
| stop | input | 1 | Consumer request to finish after the current page |
| cfg_we_len | input | TW | Write strobe low time minus one, in clocks |
| cfg_re_len | input | TW | Read strobe low time minus one, in clocks |
| cfg_setup_len | input | TW | Setup/recovery time minus one, in clocks |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_o | output | 8 | Data bus output value |
| nd_dq_oe | output | 1 | Data bus output enable |
| nd_dq_i | input | 8 | Data bus input value |
| nd_rb | input | 1 | Ready (1) / busy (0) from the device |
| out_valid | output | 1 | One-clock strobe per delivered byte |
| out_data | output | 8 | Delivered byte |
| out_spare | output | 1 | 1 when the byte comes from the spare area |

## Verification
The bench models a flash device that logs every latched command and address, runs a busy period of set length, and returns bytes computed from page and column. Six configurations vary the strobe widths, the setup time and the busy length from 2 to 30 clocks. Varying widths exposes any off-by-one in the programmable timers. Short and long busy periods separate a reader that really waits for the low-then-high edge from one that merely polls ready.

Stop points fall early in the lower half, inside the spare area, in the second and third pages, on the last spare byte, and on the first byte of the next page. Together they pin down the exact page boundary where a stop takes effect. A repeated start during reading and a reset during a read cover R10 and R1.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int MAIN_BYTES  = 512;
    localparam int HALF_BYTES  = MAIN_BYTES / 2;
    localparam int SPARE_BYTES = 16;
    localparam int ADDR_CYCLES = 4;
    localparam int PAGE_AW     = 8 * (ADDR_CYCLES - 1);
    localparam int CNT_W       = $clog2(HALF_BYTES);

    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_RD_LO = 8'h00;
    localparam logic [7:0] CMD_RD_HI = 8'h01;
    localparam logic [7:0] CMD_RD_SP = 8'h50;

    typedef enum logic [1:0] {RG_RST, RG_LO, RG_HI, RG_SP} region_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WSET, ST_WLOW, ST_BSYLO, ST_BSYHI, ST_RLOW, ST_RREC
    } state_e;

    function automatic logic [7:0] region_cmd(region_e r);
        case (r)
            RG_RST:  return CMD_RESET;
            RG_LO:   return CMD_RD_LO;
            RG_HI:   return CMD_RD_HI;
            default: return CMD_RD_SP;
        endcase
    endfunction

    // byte driven in write slot idx: 0 = command, 1 = column, 2..4 = page bytes
    function automatic logic [7:0] wr_byte(region_e r, logic [2:0] idx,
                                           logic [PAGE_AW-1:0] pg);
        case (idx)
            3'd0:    return region_cmd(r);
            3'd1:    return 8'h00;
            3'd2:    return pg[7:0];
            3'd3:    return pg[15:8];
            default: return pg[23:16];
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] region_last(region_e r);
        if (r == RG_SP) return CNT_W'(SPARE_BYTES - 1);
        return CNT_W'(HALF_BYTES - 1);
    endfunction
endpackage

// File: rtl/nbr_timer.sv
module nbr_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= len;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbr_cursor.sv
module nbr_cursor
    import nbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               page_clr,
    input  logic               page_inc,
    input  logic               byte_clr,
    input  logic               byte_inc,
    input  region_e            region,
    output logic [PAGE_AW-1:0] page,
    output logic               byte_last
);
    logic [CNT_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst || page_clr) page <= '0;
        else if (page_inc)   page <= page + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || byte_clr) byte_q <= '0;
        else if (byte_inc)   byte_q <= byte_q + 1'b1;
    end

    assign byte_last = (byte_q == region_last(region));
endmodule

// File: rtl/nand_boot_rd.sv
module nand_boot_rd
    import nbr_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [TW-1:0] cfg_we_len,
    input  logic [TW-1:0] cfg_re_len,
    input  logic [TW-1:0] cfg_setup_len,
    output logic          nd_ce_n,
    output logic          nd_cle,
    output logic          nd_ale,
    output logic          nd_we_n,
    output logic          nd_re_n,
    output logic [7:0]    nd_dq_o,
    output logic          nd_dq_oe,
    input  logic [7:0]    nd_dq_i,
    input  logic          nd_rb,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_spare
);
    state_e  state_q, state_d;
    region_e region_q, region_d;
    logic [2:0] widx_q, widx_d;
    logic stop_pend_q, stop_now;
    logic t_load, t_exp;
    logic [TW-1:0] t_len;
    logic page_clr, page_inc, byte_clr, byte_inc, byte_last;
    logic [PAGE_AW-1:0] page;
    logic wr_phase;

    nbr_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .len(t_len), .expired(t_exp)
    );

    nbr_cursor i_cursor (
        .clk(clk), .rst(rst),
        .page_clr(page_clr), .page_inc(page_inc),
        .byte_clr(byte_clr), .byte_inc(byte_inc),
        .region(region_q), .page(page), .byte_last(byte_last)
    );

    assign stop_now = stop_pend_q | stop;

    always_comb begin
        state_d  = state_q;
        region_d = region_q;
        widx_d   = widx_q;
        page_clr = 1'b0;
        page_inc = 1'b0;
        byte_clr = 1'b0;
        byte_inc = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_WSET;
                region_d = RG_RST;
                widx_d   = '0;
                page_clr = 1'b1;
            end
            ST_WSET: if (t_exp) state_d = ST_WLOW;
            ST_WLOW: if (t_exp) begin
                if (region_q == RG_RST || widx_q == 3'(ADDR_CYCLES)) begin
                    state_d = ST_BSYLO;
                end else begin
                    widx_d  = widx_q + 1'b1;
                    state_d = ST_WSET;
                end
            end
            ST_BSYLO: if (!nd_rb) state_d = ST_BSYHI;
            ST_BSYHI: if (nd_rb) begin
                if (region_q == RG_RST) begin
                    region_d = RG_LO;
                    widx_d   = '0;
                    state_d  = ST_WSET;
                end else begin
                    byte_clr = 1'b1;
                    state_d  = ST_RLOW;
                end
            end
            ST_RLOW: if (t_exp) state_d = ST_RREC;
            ST_RREC: if (t_exp) begin
                if (!byte_last) begin
                    byte_inc = 1'b1;
                    state_d  = ST_RLOW;
                end else begin
                    widx_d  = '0;
                    state_d = ST_WSET;
                    case (region_q)
                        RG_LO: region_d = RG_HI;
                        RG_HI: region_d = RG_SP;
                        default: begin
                            page_inc = 1'b1;
                            region_d = RG_LO;
                            if (stop_now) state_d = ST_IDLE;
                        end
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign t_load = (state_d != state_q);
    always_comb begin
        case (state_d)
            ST_WLOW: t_len = cfg_we_len;
            ST_RLOW: t_len = cfg_re_len;
            default: t_len = cfg_setup_len;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            region_q    <= RG_RST;
            widx_q      <= '0;
            stop_pend_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            region_q <= region_d;
            widx_q   <= widx_d;
            if (state_d == ST_IDLE)                  stop_pend_q <= 1'b0;
            else if (state_q != ST_IDLE && stop)     stop_pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_spare <= 1'b0;
        end else begin
            out_valid <= (state_q == ST_RLOW) && t_exp;
            if ((state_q == ST_RLOW) && t_exp) begin
                out_data  <= nd_dq_i;
                out_spare <= (region_q == RG_SP);
            end
        end
    end

    assign wr_phase = (state_q == ST_WSET) || (state_q == ST_WLOW);
    assign nd_ce_n  = (state_q == ST_IDLE);
    assign nd_we_n  = (state_q != ST_WLOW);
    assign nd_re_n  = (state_q != ST_RLOW);
    assign nd_cle   = wr_phase && (widx_q == '0);
    assign nd_ale   = wr_phase && (widx_q != '0);
    assign nd_dq_oe = wr_phase;
    assign nd_dq_o  = wr_phase ? wr_byte(region_q, widx_q, page) : 8'h00;
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker (
    input logic       clk,
    input logic       rst,
    input logic       nd_ce_n,
    input logic       nd_cle,
    input logic       nd_ale,
    input logic       nd_we_n,
    input logic       nd_re_n,
    input logic [7:0] nd_dq_o,
    input logic       nd_dq_oe,
    input logic       nd_rb,
    input logic       out_valid
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        nd_ce_n |-> (nd_we_n && nd_re_n && !nd_dq_oe && !out_valid));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(!nd_we_n && !nd_re_n));

    assert_drive_writes_R11: assert property (@(posedge clk) disable iff (rst)
        nd_dq_oe |-> (nd_cle ^ nd_ale));

    assert_valid_on_re_rise_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $rose(nd_re_n));

    assert_read_when_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(nd_re_n) |-> nd_rb);

    assert_write_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !nd_we_n |-> ($stable(nd_dq_o) && $stable(nd_cle) && $stable(nd_ale)));
endmodule

bind nand_boot_rd nbr_checker i_nbr_checker (
    .clk(clk), .rst(rst), .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
    .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_dq_o(nd_dq_o),
    .nd_dq_oe(nd_dq_oe), .nd_rb(nd_rb), .out_valid(out_valid)
);

// File: tb/test_nand_boot_rd.sv
module test_nand_boot_rd;
    localparam int TW = 4;
    localparam int PB = 528;
    localparam int NV = 6;
    // {we[35:32], re[31:28], setup[27:24], busy[23:16], stop_at[15:0]}
    localparam logic [35:0] VEC [NV] = '{
        {4'd0, 4'd0, 4'd0, 8'd3,  16'd10},
        {4'd1, 4'd0, 4'd1, 8'd8,  16'd520},
        {4'd2, 4'd1, 4'd0, 8'd20, 16'd600},
        {4'd0, 4'd2, 4'd2, 8'd4,  16'd1100},
        {4'd3, 4'd3, 4'd3, 8'd30, 16'd528},
        {4'd1, 4'd1, 4'd0, 8'd2,  16'd529}
    };

    logic clk = 0, rst = 1, start = 0, stop = 0;
    logic [TW-1:0] cfg_we_len = 0, cfg_re_len = 0, cfg_setup_len = 0;
    logic nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe, nd_rb;
    logic [7:0] nd_dq_o, nd_dq_i;
    logic out_valid, out_spare;
    logic [7:0] out_data;

    int total = 0, bad = 0, cyc = 0, tbusy = 2;

    always #10 clk = ~clk;

    nand_boot_rd #(.TW(TW)) i_nand_boot_rd (.*);

    function automatic logic [7:0] main_byte(int col, int pg);
        return 8'((col + 3 * pg) & 255);
    endfunction
    function automatic logic [7:0] spare_byte(int s, int pg);
        return 8'hA0 ^ 8'(s) ^ 8'(pg);
    endfunction

    // ---------------- flash device model ----------------
    int busy_cnt, wl, rl, col, pg, addr_n, log_n, v_busy, v_we, v_re;
    logic we_p, re_p, l_cle, l_ale;
    logic [7:0] l_dq, cmd, a0, a1, a2;
    logic [8:0] log_e [64];

    assign nd_rb   = (busy_cnt == 0);
    assign nd_dq_i = (col < 512) ? main_byte(col, pg) : spare_byte(col - 512, pg);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            busy_cnt <= 0; wl <= 0; rl <= 0; col <= 0; pg <= 0; addr_n <= 0;
            log_n <= 0; v_busy <= 0; v_we <= 0; v_re <= 0; we_p <= 1; re_p <= 1;
            cmd <= 0;
        end else begin
            if (!nd_we_n) begin
                wl <= wl + 1; l_cle <= nd_cle; l_ale <= nd_ale; l_dq <= nd_dq_o;
            end
            if (!nd_re_n) rl <= rl + 1;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if ((we_p && !nd_we_n || re_p && !nd_re_n) && busy_cnt != 0) v_busy <= v_busy + 1;
            if (!we_p && nd_we_n) begin
                if (wl != int'(cfg_we_len) + 1) v_we <= v_we + 1;
                wl <= 0;
                if (log_n < 64) log_e[log_n] <= {l_ale, l_dq};
                log_n <= log_n + 1;
                if (l_cle) begin
                    cmd <= l_dq; addr_n <= 0;
                    if (l_dq == 8'hFF) busy_cnt <= tbusy;
                end else if (l_ale) begin
                    addr_n <= addr_n + 1;
                    if (addr_n == 0) a0 <= l_dq;
                    if (addr_n == 1) a1 <= l_dq;
                    if (addr_n == 2) a2 <= l_dq;
                    if (addr_n == 3) begin
                        pg <= int'({l_dq, a2, a1});
                        if (cmd == 8'h00)      col <= int'(a0);
                        else if (cmd == 8'h01) col <= 256 + int'(a0);
                        else                   col <= 512 + int'(a0 & 8'h0F);
                        busy_cnt <= tbusy;
                    end
                end
            end
            if (!re_p && nd_re_n) begin
                if (rl != int'(cfg_re_len) + 1) v_re <= v_re + 1;
                rl <= 0;
                col <= col + 1;
            end
            we_p <= nd_we_n;
            re_p <= nd_re_n;
        end
    end

    // ---------------- stream monitor ----------------
    int rx_cnt, mism, last_act, last_exp;
    always @(negedge clk) begin
        if (rst) begin
            rx_cnt <= 0; mism <= 0;
        end else if (out_valid) begin
            automatic int p   = rx_cnt / PB;
            automatic int off = rx_cnt % PB;
            automatic logic [8:0] e = (off < 512) ? {1'b0, main_byte(off, p)}
                                                  : {1'b1, spare_byte(off - 512, p)};
            if ({out_spare, out_data} != e) begin
                mism <= mism + 1; last_act <= int'({out_spare, out_data}); last_exp <= int'(e);
            end
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_log(int i);
        int j, p, r, ci, a;
        logic [7:0] cm;
        if (i == 0) return {1'b0, 8'hFF};
        j = i - 1; p = j / 15; r = j % 15; ci = r / 5; a = r % 5;
        cm = (ci == 0) ? 8'h00 : (ci == 1) ? 8'h01 : 8'h50;
        if (a == 0) return {1'b0, cm};
        if (a == 2) return {1'b1, 8'(p)};
        return {1'b1, 8'h00};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; start = 0; stop = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic idle_check(input string req);
        check(nd_ce_n && nd_we_n && nd_re_n && !nd_cle && !nd_ale && !nd_dq_oe && !out_valid,
              req, int'({nd_ce_n, nd_we_n, nd_re_n, nd_cle, nd_ale, nd_dq_oe, out_valid}),
              int'(7'b1110000));
    endtask

    initial begin
        // R1: outputs during reset
        repeat (2) @(negedge clk);
        idle_check("R1 during reset");
        for (int v = 0; v < NV; v++) begin
            automatic int stop_at = int'(VEC[v][15:0]);
            automatic int pages   = (stop_at - 1) / PB + 1;
            automatic int lg_ok   = 1;
            automatic int wait_n  = 0;
            cfg_we_len = VEC[v][35:32]; cfg_re_len = VEC[v][31:28];
            cfg_setup_len = VEC[v][27:24]; tbusy = int'(VEC[v][23:16]);
            do_reset();
            idle_check("R1 after reset");
            start = 1; @(negedge clk); start = 0;
            if (stop_at > 50) begin
                // R10: second start while reading
                wait (rx_cnt >= 50);
                start = 1; @(negedge clk); start = 0;
            end
            wait (rx_cnt >= stop_at);
            stop = 1; @(negedge clk); stop = 0;
            while (!nd_ce_n && wait_n < 20000) begin @(negedge clk); wait_n++; end
            repeat (50) @(negedge clk);
            // R9: idle after finishing the page in progress
            idle_check("R9 idle after stop");
            check(rx_cnt == pages * PB, "R9 bytes delivered", rx_cnt, pages * PB);
            // R7/R8/R10: stream content and order
            check(mism == 0, "R7 R8 R10 stream content", last_act, last_exp);
            // R2/R3: command and address log
            check(log_n == 1 + 15 * pages, "R3 write count", log_n, 1 + 15 * pages);
            for (int i = 0; i < log_n && i < 64; i++)
                if (log_e[i] != exp_log(i) && lg_ok == 1) begin
                    lg_ok = 0;
                    check(0, "R2 R3 write sequence", int'(log_e[i]), int'(exp_log(i)));
                end
            if (lg_ok == 1) check(1, "R2 R3 write sequence", 0, 0);
            check(v_busy == 0, "R2 R4 strobe during busy", v_busy, 0);
            check(v_we == 0, "R5 write strobe width", v_we, 0);
            check(v_re == 0, "R6 read strobe width", v_re, 0);
        end
        // R1: reset in the middle of a read
        cfg_we_len = 0; cfg_re_len = 0; cfg_setup_len = 0; tbusy = 3;
        do_reset();
        start = 1; @(negedge clk); start = 0;
        wait (rx_cnt >= 20);
        rst = 1; @(negedge clk); @(negedge clk);
        idle_check("R1 reset mid-read");
        rst = 0;
        repeat (20) @(negedge clk);
        idle_check("R1 stays idle after mid-read reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule